// File: doc/BRIEF.md
# Banked DRAM Address Translator

The block maps a CPU linear byte address onto the physical address of a DRAM array with two banks. Each bank holds devices of one of three densities (256Kbit, 1Mbit, 4Mbit) and may be built single or two-way interleaved. Two descriptions of the array reach the block. One is the installed type of each bank, which is fixed by the board. The other is a 4-bit map code that firmware programs to state what it believes is fitted.

When the two descriptions agree, the block passes the address through linearly. When they differ, the block takes the column and row fields out of the address using the programmed geometry. It then packs them again using the installed geometry. A wrong guess therefore gives the same aliasing that real DRAM would show, and firmware uses this aliasing to size memory by probing. Some addresses fall in a hole, which is a half-width column gap that appears when an interleaved layout is programmed over a non-interleaved bank. Such addresses are flagged as open bus.

The translation is combinational and is registered once at the output.

Top module: `dram_bank_xlat`

## Requirements
- R1: While rst_ni is low, hit_o, bank_o and open_o are 0 and phys_o is 0.
- R2: Bank type codes are 0 none, 1 256K (512 KiB), 2 256K interleaved (1 MiB), 3 1M (2 MiB), 4 1M interleaved (4 MiB), 5 4M (8 MiB), 6 4M interleaved (16 MiB), and 7 counts as none. The map code selects a programmed pair {bank0, bank1}:
  - 0 {1,0}, 1 {2,0}, 2 {2,1}, 3 {2,2}
  - 4 {3,0}, 5 {4,0}, 6 {4,3}, 7 {4,4}
  - 8 {5,0}, 9 {6,0}, A {0,5}, B {0,6}
  - C {2,3}, D {2,4}, E {4,5}, F {4,6}
  
  Bank 0 starts at virtual address 0. Bank 1 starts at the programmed size of bank 0. The physical base of bank 1 is the installed size of bank 0. bank_o gives the bank that was hit.
- R3: If the programmed pair equals the installed pair, phys_o equals addr_i. In that case hit_o is 1 exactly when addr_i is below the total installed size, and bank_o is 1 when addr_i is at or above the installed size of bank 0.
- R4: For a programmed non-interleaved type, the offset is addr_i minus the bank's virtual base. With geometry g (0, 1, 2 for 256K, 1M, 4M), the mask is 2^(9+g)-1 and the row shift is 10+g. The bank-local address is offset bit 0, plus ((offset>>1) & installed mask) << 1, plus ((offset >> programmed shift) & installed mask) << installed shift.
- R5: For a programmed interleaved type over an interleaved installed bank, the column mask is (installed mask<<1)|1. The row is taken at the programmed shift + 1 and packed at the installed shift + 1.
- R6: For a programmed interleaved type over a non-interleaved installed bank:
  - If offset bit 10 is 1, the access is open bus: open_o=1, hit_o=1, phys_o=0.
  - Otherwise the offset is first compacted to (offset mod 1024) + (offset div 2048)*1024, and the R4 packing is then applied.
- R7: For map codes A and B, bank 0 is empty and bank 1 starts at virtual address 0. Every hit in these codes reports bank_o=1.
- R8: An address outside every programmed bank is a miss with hit_o=0, open_o=0 and phys_o=0. An address in a programmed bank whose installed type is none is also a miss.
- R9: Programming 4M interleaved over installed 256K DRAM uses a special row:
  - Over a non-interleaved bank, the row is compacted bits [19:13], with bit 21 placed in row bit 9, packed at the installed shift.
  - Over an interleaved bank, the row is bits [20:13], with bit 22 placed in row bit 9, packed at the installed shift + 1.
- R10: Outputs reflect the inputs present at the previous rising clock edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | CPU linear byte address |
| map_i | input | 4 | Programmed map code |
| inst0_i | input | 3 | Installed type of bank 0 |
| inst1_i | input | 3 | Installed type of bank 1 |
| hit_o | output | 1 | Address decodes to an installed, programmed bank |
| bank_o | output | 1 | Bank that was hit |
| open_o | output | 1 | Access falls in a column hole and reads as open bus |
| phys_o | output | ADDR_W | Physical DRAM array byte address |

## Verification
Every result is due one rising edge after its inputs are applied. The bench drives inputs on the falling edge and compares all four outputs on the next falling edge, which is after exactly one registering edge. To check R10, the bench also samples just after a new input is driven, before the next rising edge, and expects the previous result to still be held. The sweep runs every map code against eleven installed pairs, using boundary addresses and pseudo-random addresses. Each check is tagged with the rule that decides its expected value.

// File: rtl/dram_xlat_pkg.sv
package dram_xlat_pkg;
  localparam int TYPE_W = 3;
  localparam int MAP_W  = 4;

  typedef logic [TYPE_W-1:0] btype_t;

  localparam btype_t BT_NONE    = 3'd0;
  localparam btype_t BT_256K    = 3'd1;
  localparam btype_t BT_256K_X2 = 3'd2;
  localparam btype_t BT_1M      = 3'd3;
  localparam btype_t BT_1M_X2   = 3'd4;
  localparam btype_t BT_4M      = 3'd5;
  localparam btype_t BT_4M_X2   = 3'd6;

  function automatic btype_t norm_t(btype_t t);
    return (t == 3'd7) ? BT_NONE : t;
  endfunction

  function automatic logic is_none(btype_t t);
    return norm_t(t) == BT_NONE;
  endfunction

  function automatic logic is_ilv(btype_t t);
    return (t == BT_256K_X2) || (t == BT_1M_X2) || (t == BT_4M_X2);
  endfunction

  // 0: 256Kbit, 1: 1Mbit, 2: 4Mbit
  function automatic logic [1:0] geo(btype_t t);
    case (t)
      BT_1M, BT_1M_X2: return 2'd1;
      BT_4M, BT_4M_X2: return 2'd2;
      default:         return 2'd0;
    endcase
  endfunction

  // returns {bank1, bank0}
  function automatic logic [2*TYPE_W-1:0] map_types(logic [MAP_W-1:0] code);
    case (code)
      4'h0: return {BT_NONE,    BT_256K};
      4'h1: return {BT_NONE,    BT_256K_X2};
      4'h2: return {BT_256K,    BT_256K_X2};
      4'h3: return {BT_256K_X2, BT_256K_X2};
      4'h4: return {BT_NONE,    BT_1M};
      4'h5: return {BT_NONE,    BT_1M_X2};
      4'h6: return {BT_1M,      BT_1M_X2};
      4'h7: return {BT_1M_X2,   BT_1M_X2};
      4'h8: return {BT_NONE,    BT_4M};
      4'h9: return {BT_NONE,    BT_4M_X2};
      4'hA: return {BT_4M,      BT_NONE};
      4'hB: return {BT_4M_X2,   BT_NONE};
      4'hC: return {BT_1M,      BT_256K_X2};
      4'hD: return {BT_1M_X2,   BT_256K_X2};
      4'hE: return {BT_4M,      BT_1M_X2};
      default: return {BT_4M_X2, BT_1M_X2};
    endcase
  endfunction
endpackage

// File: rtl/xlat_map_decode.sv
module xlat_map_decode
  import dram_xlat_pkg::*;
#(
  parameter int ADDR_W = 25
) (
  input  logic [MAP_W-1:0]  map_i,
  input  btype_t            inst_i   [2],
  output btype_t            prog_o   [2],
  output logic [ADDR_W-1:0] vbase_o  [2],
  output logic [ADDR_W:0]   vend_o   [2],
  output logic [ADDR_W-1:0] pbase_o  [2],
  output logic [ADDR_W:0]   inst_end_o,
  output logic              lin_o
);
  localparam int NB   = 2;
  localparam int SZ_W = ADDR_W + 1;

  function automatic logic [ADDR_W-1:0] bsize(btype_t t);
    logic [4:0] lg;
    if (is_none(t)) return '0;
    lg = 5'd19 + 5'({geo(t), 1'b0}) + 5'(is_ilv(t));
    return ADDR_W'(1) << lg;
  endfunction

  logic [2*TYPE_W-1:0] pair;
  logic [ADDR_W-1:0]   sz_p [NB];
  logic [ADDR_W-1:0]   sz_i [NB];

  assign pair      = map_types(map_i);
  assign prog_o[0] = pair[TYPE_W-1:0];
  assign prog_o[1] = pair[2*TYPE_W-1:TYPE_W];

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_sz
      assign sz_p[b] = bsize(prog_o[b]);
      assign sz_i[b] = bsize(inst_i[b]);
    end
  endgenerate

  assign vbase_o[0] = '0;
  assign vbase_o[1] = sz_p[0];
  assign vend_o[0]  = SZ_W'(sz_p[0]);
  assign vend_o[1]  = SZ_W'(sz_p[0]) + SZ_W'(sz_p[1]);
  assign pbase_o[0] = '0;
  assign pbase_o[1] = sz_i[0];
  assign inst_end_o = SZ_W'(sz_i[0]) + SZ_W'(sz_i[1]);

  assign lin_o = (norm_t(prog_o[0]) == norm_t(inst_i[0])) &&
                 (norm_t(prog_o[1]) == norm_t(inst_i[1]));
endmodule

// File: rtl/xlat_bank.sv
module xlat_bank
  import dram_xlat_pkg::*;
#(
  parameter int ADDR_W = 25
) (
  input  logic [ADDR_W-1:0] off_i,
  input  btype_t            prog_i,
  input  btype_t            inst_i,
  output logic [ADDR_W-1:0] phys_o,
  output logic              open_o
);
  localparam logic [ADDR_W-1:0] LO_KEEP = ADDR_W'('h3FF);
  localparam logic [ADDR_W-1:0] HI_KEEP = ~ADDR_W'('h7FF);

  logic              pil, qil, spec, both_il;
  logic [1:0]        gp, gq;
  logic [3:0]        psh, qsh, rsh;
  logic [ADDR_W-1:0] qmask, o2, col, row;

  always_comb begin
    pil     = is_ilv(prog_i);
    qil     = is_ilv(inst_i);
    both_il = pil && qil;
    gp      = geo(prog_i);
    gq      = geo(inst_i);
    spec    = (norm_t(prog_i) == BT_4M_X2) && (gq == 2'd0);
    psh     = 4'd10 + 4'(gp);
    qsh     = 4'd10 + 4'(gq);
    qmask   = (ADDR_W'(1) << (4'd9 + 4'(gq))) - ADDR_W'(1);

    // interleaved layout over a single bank: half-width column hole
    open_o = 1'b0;
    o2     = off_i;
    if (pil && !qil) begin
      open_o = off_i[10];
      o2     = (off_i & LO_KEEP) | ((off_i & HI_KEEP) >> 1);
    end

    if (both_il) col = (o2 >> 1) & {qmask[ADDR_W-2:0], 1'b1};
    else         col = (o2 >> 1) & qmask;

    if (spec) begin
      if (qil) row = ADDR_W'(o2[20:13]) | (ADDR_W'(o2[22]) << 9);
      else     row = ADDR_W'(o2[19:13]) | (ADDR_W'(o2[21]) << 9);
    end else if (both_il) begin
      row = (o2 >> (psh + 4'd1)) & qmask;
    end else begin
      row = (o2 >> psh) & qmask;
    end

    rsh    = qsh + 4'(both_il);
    phys_o = open_o ? '0 : (ADDR_W'(o2[0]) | (col << 1) | (row << rsh));
  end
endmodule

// File: rtl/dram_bank_xlat.sv
module dram_bank_xlat
  import dram_xlat_pkg::*;
#(
  parameter int ADDR_W = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        map_i,
  input  logic [2:0]        inst0_i,
  input  logic [2:0]        inst1_i,
  output logic              hit_o,
  output logic              bank_o,
  output logic              open_o,
  output logic [ADDR_W-1:0] phys_o
);
  localparam int NB   = 2;
  localparam int SZ_W = ADDR_W + 1;

  btype_t            inst_t [NB];
  btype_t            prog_t [NB];
  logic [ADDR_W-1:0] vbase  [NB];
  logic [SZ_W-1:0]   vend   [NB];
  logic [ADDR_W-1:0] pbase  [NB];
  logic [ADDR_W-1:0] off    [NB];
  logic [ADDR_W-1:0] bphys  [NB];
  logic [NB-1:0]     bopen, bhit;
  logic [SZ_W-1:0]   inst_end, addr_x;
  logic              lin_c, remap_c;
  logic              hit_c, bank_c, open_c;
  logic [ADDR_W-1:0] phys_c;

  assign inst_t[0] = inst0_i;
  assign inst_t[1] = inst1_i;
  assign addr_x    = {1'b0, addr_i};
  assign remap_c   = is_none(prog_t[0]);

  xlat_map_decode #(.ADDR_W(ADDR_W)) u_map (
    .map_i      (map_i),
    .inst_i     (inst_t),
    .prog_o     (prog_t),
    .vbase_o    (vbase),
    .vend_o     (vend),
    .pbase_o    (pbase),
    .inst_end_o (inst_end),
    .lin_o      (lin_c)
  );

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_bank
      assign off[b]  = addr_i - vbase[b];
      assign bhit[b] = !is_none(prog_t[b]) && !is_none(inst_t[b]) &&
                       (addr_i >= vbase[b]) && (addr_x < vend[b]);
      xlat_bank #(.ADDR_W(ADDR_W)) u_xb (
        .off_i  (off[b]),
        .prog_i (prog_t[b]),
        .inst_i (inst_t[b]),
        .phys_o (bphys[b]),
        .open_o (bopen[b])
      );
    end
  endgenerate

  always_comb begin
    hit_c  = 1'b0;
    bank_c = 1'b0;
    open_c = 1'b0;
    phys_c = '0;
    if (lin_c) begin
      hit_c  = addr_x < inst_end;
      bank_c = hit_c && (addr_i >= pbase[1]);
      phys_c = hit_c ? addr_i : '0;
    end else if (bhit[0]) begin
      hit_c  = 1'b1;
      open_c = bopen[0];
      phys_c = open_c ? '0 : (pbase[0] + bphys[0]);
    end else if (bhit[1]) begin
      hit_c  = 1'b1;
      bank_c = 1'b1;
      open_c = bopen[1];
      phys_c = open_c ? '0 : (pbase[1] + bphys[1]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o  <= 1'b0;
      bank_o <= 1'b0;
      open_o <= 1'b0;
      phys_o <= '0;
    end else begin
      hit_o  <= hit_c;
      bank_o <= bank_c;
      open_o <= open_c;
      phys_o <= phys_c;
    end
  end

  // R8
  miss_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (phys_o == '0 && !open_o));

  // R6
  open_hole_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |-> (hit_o && phys_o == '0));

  // R3
  linear_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && $past(lin_c)) |-> (phys_o == $past(addr_i) && !open_o));

  // R7
  remap_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !$past(lin_c) && $past(remap_c)) |-> bank_o);

  // R2
  bank1_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && bank_o && !$past(lin_c)) |-> ($past(addr_i) >= $past(vbase[1])));
endmodule

// File: tb/sim_dram_bank_xlat.sv
`timescale 1ns/1ps
module sim_dram_bank_xlat;
  localparam int AW = 25;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    map = '0;
  logic [2:0]    inst0 = '0, inst1 = '0;
  logic          hit, bank, opn;
  logic [AW-1:0] phys;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  always #4 clk = ~clk;

  dram_bank_xlat #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .map_i(map),
    .inst0_i(inst0), .inst1_i(inst1),
    .hit_o(hit), .bank_o(bank), .open_o(opn), .phys_o(phys)
  );

  int p0_tab [16] = '{1,2,2,2,3,4,4,4,5,6,0,0,2,2,4,4};
  int p1_tab [16] = '{0,0,1,2,0,0,3,4,0,0,5,6,3,4,5,6};
  int c0_tab [11] = '{1,2,2,2,2,4,2,4,4,4,6};
  int c1_tab [11] = '{0,0,1,2,3,0,4,3,4,5,0};

  function automatic int unsigned sz(int t);
    case (t)
      1: return 32'd524288;
      2: return 32'd1048576;
      3: return 32'd2097152;
      4: return 32'd4194304;
      5: return 32'd8388608;
      6: return 32'd16777216;
      default: return 0;
    endcase
  endfunction
  function automatic int gq_of(int t);
    return (t == 3 || t == 4) ? 1 : ((t == 5 || t == 6) ? 2 : 0);
  endfunction
  function automatic bit il_of(int t);
    return (t == 2 || t == 4 || t == 6);
  endfunction
  function automatic int unsigned p2(int n);
    return 32'd1 << n;
  endfunction

  task automatic model(input int unsigned a, input int code, input int i0, input int i1,
                       output bit h, output bit bk, output bit op,
                       output int unsigned ph, output string tag);
    int p0, p1, p, q, gp, gq, rsh;
    bit pil, qil;
    int unsigned vb1, off, o2, col, row, base;
    p0 = p1_dummy(code, 0); p1 = p1_dummy(code, 1);
    h = 0; bk = 0; op = 0; ph = 0;
    if (p0 == i0 && p1 == i1) begin
      tag = "R3";
      h   = a < sz(i0) + sz(i1);
      bk  = h && (a >= sz(i0));
      ph  = h ? a : 0;
      return;
    end
    vb1 = sz(p0);
    if (p0 != 0 && i0 != 0 && a < sz(p0)) begin
      bk = 0; p = p0; q = i0; off = a; base = 0;
    end else if (p1 != 0 && i1 != 0 && a >= vb1 && a < vb1 + sz(p1)) begin
      bk = 1; p = p1; q = i1; off = a - vb1; base = sz(i0);
    end else begin
      tag = "R8";
      return;
    end
    h = 1;
    pil = il_of(p); qil = il_of(q); gp = gq_of(p); gq = gq_of(q);
    o2 = off;
    if (pil && !qil) begin
      if ((off / 1024) % 2 == 1) begin
        op = 1; ph = 0; tag = "R6";
        return;
      end
      o2 = (off % 1024) + (off / 2048) * 1024;
    end
    if (pil && qil) col = (o2 / 2) % p2(10 + gq);
    else            col = (o2 / 2) % p2(9 + gq);
    if (p == 6 && gq == 0) begin
      if (qil) row = (o2 / p2(13)) % 256 + ((o2 / p2(22)) % 2) * 512;
      else     row = (o2 / p2(13)) % 128 + ((o2 / p2(21)) % 2) * 512;
    end else if (pil && qil) row = (o2 / p2(11 + gp)) % p2(9 + gq);
    else                     row = (o2 / p2(10 + gp)) % p2(9 + gq);
    rsh = 10 + gq + ((pil && qil) ? 1 : 0);
    ph  = base + (o2 % 2) + col * 2 + row * p2(rsh);
    if (code == 10 || code == 11) tag = "R7";
    else if (p == 6 && gq == 0)   tag = "R9";
    else if (pil && !qil)         tag = "R6";
    else if (pil && qil)          tag = "R5";
    else if (bk)                  tag = "R2";
    else                          tag = "R4";
  endtask

  function automatic int p1_dummy(int code, int which);
    return which ? p1_tab[code] : p0_tab[code];
  endfunction

  task automatic check(input string tag, input bit eh, input bit ebk, input bit eop,
                       input int unsigned eph);
    n_tests++;
    if (hit !== eh || bank !== ebk || opn !== eop || phys !== AW'(eph)) begin
      n_fail++;
      $display("FAIL %s addr=%h map=%h inst=%0d/%0d actual hit=%b bank=%b open=%b phys=%h expected hit=%b bank=%b open=%b phys=%h",
               tag, addr, map, inst0, inst1, hit, bank, opn, phys, eh, ebk, eop, AW'(eph));
    end
  endtask

  bit          pv_h, pv_b, pv_o;
  int unsigned pv_p;

  task automatic run_vec(input int unsigned a, input int code, input int i0, input int i1,
                         input bit lat_chk);
    bit h, bk, op; int unsigned ph; string tag;
    model(a, code, i0, i1, h, bk, op, ph, tag);
    @(negedge clk);
    addr = AW'(a); map = 4'(code); inst0 = 3'(i0); inst1 = 3'(i1);
    if (lat_chk) begin
      #1;
      check("R10", pv_h, pv_b, pv_o, pv_p);
    end
    @(negedge clk);
    check(tag, h, bk, op, ph);
    pv_h = h; pv_b = bk; pv_o = op; pv_p = ph;
  endtask

  initial begin
    int unsigned lfsr, a, s0, s1, ie, m;
    lfsr = 32'hACE1_2345;
    addr = AW'(5); map = 4'h3; inst0 = 3'd2; inst1 = 3'd2;
    repeat (3) @(negedge clk);
    check("R1", 0, 0, 0, 0);
    rst_n = 1'b1;
    run_vec(5, 3, 2, 2, 0);
    for (int ci = 0; ci < 11; ci++) begin
      for (int code = 0; code < 16; code++) begin
        s0 = sz(p0_tab[code]); s1 = sz(p1_tab[code]);
        ie = sz(c0_tab[ci]) + sz(c1_tab[ci]);
        for (int k = 0; k < 48; k++) begin
          case (k)
            0: a = 0;
            1: a = 32'h400;
            2: a = 32'h7FF;
            3: a = s0 - 1;
            4: a = s0;
            5: a = s0 + 32'h400;
            6: a = s0 + s1 - 1;
            7: a = s0 + s1;
            8: a = ie - 1;
            9: a = ie;
            default: begin
              lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
              m = (k % 7 == 0) ? 25 : 19 + (k % 6);
              a = lfsr;
              a = a % p2(m);
            end
          endcase
          a = a % p2(AW);
          run_vec(a, code, c0_tab[ci], c1_tab[ci], k == 0);
        end
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule